// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers thirty-two maskable interrupt lines and one non-maskable line. It keeps an enable flag, a pending flag and a two-level-bit priority for every maskable line. At any moment it offers the core one request: the most urgent line that is pending, enabled and more urgent than everything the core is already servicing. Lines 0 to 15 are level-sensitive and lines 16 to 31 are pulse-sensitive, which is set by the `LEVEL_MASK` parameter. The non-maskable line is always edge-latched.

The core takes an offer by raising `req_ack` while `req_valid` is high. This is a valid/ready pair. The core may hold `req_ack` low for as long as it likes, and the offer stays up. The offer is not frozen while it waits: a more urgent arrival replaces it, so the core must read `req_nmi`/`req_id` in the cycle it acknowledges. A one-cycle `cpl` strobe ends the most urgent handler in service. In that same cycle the offer already reflects the reduced active set, so a waiting request can be taken back to back (tail-chaining).

Software reaches the flags through a simple word-addressed port. Writes take effect on the clock edge. Reads are combinational from the word address.

Top module: `prio_intc`

## Requirements
- R1: After reset, every enable, pending and priority register reads 0x00000000 and `req_valid` is low.
- R2: Byte offset 0x000 sets enables and offset 0x080 clears enables, one bit per line, write-one-to-act. Writing zero bits changes nothing. Reading either offset returns the enable vector.
- R3: Byte offset 0x100 sets pending flags and offset 0x180 clears them, write-one-to-act. Reading either offset returns the pending vector.
- R4: The word at 0x300+4k holds the priorities of lines 4k to 4k+3. Line 4k+j uses bits [8j+7:8j+6] of that word. All other bits read as zero.
- R5: A pulse line (16 to 31) becomes pending on a rising edge only, so a cleared flag stays clear while the line is held high. A level line (0 to 15) is re-marked pending on every cycle that it is high.
- R6: The maskable offer is the enabled, pending line with the numerically lowest priority. Among lines with equal priority, the lowest line number wins. `req_id` reads 0 when no maskable line is offered.
- R7: An acknowledge clears the taken line's pending flag and marks it active. A line is offered only if its level is strictly more urgent than every active line.
- R8: `cpl` clears the active mark of the most urgent line in service, or of the non-maskable handler if it is active. In the same cycle the offer is computed as if that mark were already gone.
- R9: A rising edge on `nmi_in` latches a non-maskable request. This request ignores enables, outranks all maskable lines and is flagged by `req_nmi`. While it is active, nothing is offered.
- R10: A new hardware event on a line in the same cycle as that line's acknowledge or software clear leaves the line pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | 32 | Maskable interrupt lines |
| nmi_in | input | 1 | Non-maskable interrupt line |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| req_valid | output | 1 | A request is offered to the core |
| req_nmi | output | 1 | Offered request is the non-maskable one |
| req_id | output | 5 | Offered maskable line number |
| req_ack | input | 1 | Core takes the offered request |
| cpl | input | 1 | Handler completion strobe |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a completion strobe and a new acknowledge: in that cycle the offer must already exclude the finished handler. The second pair is a fresh hardware event on a line and that line's acknowledge or software clear, where the line must end up pending. Directed sequences set up both collisions on purpose, and a long seeded random run drives `ack`, `cpl`, line edges and register writes independently so that they overlap often. A cycle-accurate reference model in the bench predicts the offer and every readback, and both are compared in each cycle.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  // Word addresses (byte address >> 2) of the register groups
  localparam logic [9:0] WA_EN_SET    = 10'h000;
  localparam logic [9:0] WA_EN_CLR    = 10'h020;
  localparam logic [9:0] WA_PD_SET    = 10'h040;
  localparam logic [9:0] WA_PD_CLR    = 10'h060;
  localparam logic [9:0] WA_PRIO_BASE = 10'h0C0;

  // Byte lane width inside a priority word
  localparam int unsigned SLOT_W = 8;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_EN_SET,
    RG_EN_CLR,
    RG_PD_SET,
    RG_PD_CLR,
    RG_PRIO
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [9:0] w, input int unsigned prio_words);
    reg_sel_e s;
    s = RG_NONE;
    if (w == WA_EN_SET) s = RG_EN_SET;
    else if (w == WA_EN_CLR) s = RG_EN_CLR;
    else if (w == WA_PD_SET) s = RG_PD_SET;
    else if (w == WA_PD_CLR) s = RG_PD_CLR;
    else if (w >= WA_PRIO_BASE && w < WA_PRIO_BASE + 10'(prio_words)) s = RG_PRIO;
    return s;
  endfunction

endpackage

// File: rtl/prio_intc_detect.sv
module prio_intc_detect #(
  parameter int unsigned N_IRQ = 32,
  parameter logic [N_IRQ-1:0] LEVEL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             nmi_in,
  output logic [N_IRQ-1:0] hw_set,
  output logic             nmi_edge
);

  logic [N_IRQ-1:0] irq_prev;
  logic             nmi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev <= '0;
      nmi_prev <= 1'b0;
    end else begin
      irq_prev <= irq_in;
      nmi_prev <= nmi_in;
    end
  end

  // Per-line variant picked by the mask: level lines follow the input,
  // pulse lines fire on a low-to-high transition only.
  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    if (LEVEL_MASK[g]) begin : g_level
      assign hw_set[g] = irq_in[g];
    end else begin : g_pulse
      assign hw_set[g] = irq_in[g] & ~irq_prev[g];
    end
  end

  assign nmi_edge = nmi_in & ~nmi_prev;

endmodule

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned PRIO_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [9:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [N_IRQ-1:0]        hw_set,
  input  logic [N_IRQ-1:0]        ack_clr,
  output logic [N_IRQ-1:0]        enable,
  output logic [N_IRQ-1:0]        pending,
  output logic [N_IRQ*PRIO_W-1:0] prio_flat
);

  localparam int unsigned PRIO_WORDS = N_IRQ / 4;

  reg_sel_e         sel;
  logic             wr;
  logic [9:0]       pidx;
  logic [N_IRQ-1:0] pd_set_v, pd_clr_v;
  logic [PRIO_W-1:0] prio_q [N_IRQ];

  assign sel  = decode_word(bus_addr, PRIO_WORDS);
  assign wr   = bus_valid & bus_write;
  assign pidx = bus_addr - WA_PRIO_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
    end else if (wr && sel == RG_EN_SET) begin
      enable <= enable | bus_wdata[N_IRQ-1:0];
    end else if (wr && sel == RG_EN_CLR) begin
      enable <= enable & ~bus_wdata[N_IRQ-1:0];
    end
  end

  // Set sources win over clear sources so a fresh event is never lost
  assign pd_set_v = ((wr && sel == RG_PD_SET) ? bus_wdata[N_IRQ-1:0] : '0) | hw_set;
  assign pd_clr_v = ((wr && sel == RG_PD_CLR) ? bus_wdata[N_IRQ-1:0] : '0) | ack_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~pd_clr_v) | pd_set_v;
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[g] <= '0;
      end else if (wr && sel == RG_PRIO && pidx == 10'(g / 4)) begin
        prio_q[g] <= bus_wdata[(g % 4) * SLOT_W + SLOT_W - 1 -: PRIO_W];
      end
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RG_EN_SET, RG_EN_CLR: bus_rdata = 32'(enable);
      RG_PD_SET, RG_PD_CLR: bus_rdata = 32'(pending);
      RG_PRIO: begin
        for (int k = 0; k < int'(N_IRQ); k++) begin
          if (10'(k / 4) == pidx)
            bus_rdata[(k % 4) * SLOT_W + SLOT_W - 1 -: PRIO_W] = prio_q[k];
        end
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_ZERO_WRITE_KEEPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) bus_valid && bus_write && (sel == RG_EN_SET || sel == RG_EN_CLR) && bus_wdata == 32'd0 |=> enable == $past(enable)); // R2

endmodule

// File: rtl/prio_intc_pick.sv
module prio_intc_pick #(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned IDW   = $clog2(N_IRQ),
  localparam int unsigned LVL_W = PRIO_W + 1
) (
  input  logic [N_IRQ-1:0]        cand,
  input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
  input  logic [LVL_W-1:0]        ceiling,
  output logic                    found,
  output logic [IDW-1:0]          id
);

  logic [LVL_W-1:0] best;

  // Strictly-less compare while scanning upward keeps the lowest index on ties
  always_comb begin
    best  = ceiling;
    found = 1'b0;
    id    = '0;
    for (int i = 0; i < int'(N_IRQ); i++) begin
      if (cand[i] && {1'b0, prio_flat[i*PRIO_W +: PRIO_W]} < best) begin
        best  = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]};
        found = 1'b1;
        id    = IDW'(i);
      end
    end
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned PRIO_W = 2,
  parameter logic [N_IRQ-1:0] LEVEL_MASK = 32'h0000_FFFF,
  localparam int unsigned IDW   = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             nmi_in,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [9:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             req_valid,
  output logic             req_nmi,
  output logic [IDW-1:0]   req_id,
  input  logic             req_ack,
  input  logic             cpl
);

  localparam int unsigned LVL_W = PRIO_W + 1;
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(1 << PRIO_W);

  logic [N_IRQ-1:0]        hw_set, enable, pending, ack_clr;
  logic [N_IRQ*PRIO_W-1:0] prio_flat;
  logic                    nmi_edge;

  logic [N_IRQ-1:0] act_q, clr_act, eff_act;
  logic             nmi_pend_q, nmi_act_q, eff_nmi_act;
  logic             top_found, nxt_found, disp_found;
  logic [IDW-1:0]   top_id, nxt_id, disp_id;
  logic [LVL_W-1:0] ceiling;
  logic             nmi_req, mask_req, take;

  prio_intc_detect #(.N_IRQ(N_IRQ), .LEVEL_MASK(LEVEL_MASK)) u_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .hw_set(hw_set), .nmi_edge(nmi_edge)
  );

  prio_intc_regs #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_set(hw_set), .ack_clr(ack_clr),
    .enable(enable), .pending(pending), .prio_flat(prio_flat)
  );

  // Most urgent handler in service: the one a completion retires
  prio_intc_pick #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_act_top (
    .cand(act_q), .prio_flat(prio_flat), .ceiling(LVL_IDLE),
    .found(top_found), .id(top_id)
  );

  assign clr_act     = (cpl && !nmi_act_q && top_found) ? (N_IRQ'(1) << top_id) : '0;
  assign eff_act     = act_q & ~clr_act;
  assign eff_nmi_act = nmi_act_q & ~cpl;

  // Most urgent handler left after this cycle's completion sets the ceiling
  prio_intc_pick #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_act_nxt (
    .cand(eff_act), .prio_flat(prio_flat), .ceiling(LVL_IDLE),
    .found(nxt_found), .id(nxt_id)
  );

  assign ceiling = nxt_found ? {1'b0, prio_flat[nxt_id*PRIO_W +: PRIO_W]} : LVL_IDLE;

  prio_intc_pick #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_disp (
    .cand(enable & pending), .prio_flat(prio_flat), .ceiling(ceiling),
    .found(disp_found), .id(disp_id)
  );

  assign nmi_req   = nmi_pend_q & ~eff_nmi_act;
  assign mask_req  = ~eff_nmi_act & disp_found;
  assign req_valid = nmi_req | mask_req;
  assign req_nmi   = nmi_req;
  assign req_id    = (!nmi_req && mask_req) ? disp_id : '0;
  assign take      = req_valid & req_ack;
  assign ack_clr   = (take && !nmi_req) ? (N_IRQ'(1) << disp_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= '0;
      nmi_act_q  <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      act_q      <= eff_act | ack_clr;
      nmi_act_q  <= eff_nmi_act | (take & nmi_req);
      nmi_pend_q <= (nmi_pend_q & ~(take & nmi_req)) | nmi_edge;
    end
  end

  AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !req_nmi |-> enable[req_id] && pending[req_id]); // R6
  AST_ACK_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ack && !req_nmi |=> act_q[$past(req_id)]); // R7
  AST_NO_REQ_UNDER_NMI: assert property (@(posedge clk) disable iff (!rst_n) nmi_act_q && !cpl |-> !req_valid); // R9
  AST_NMI_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(nmi_pend_q) |-> $past(nmi_in)); // R9
  AST_NMI_TAIL_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) cpl && nmi_act_q && nmi_pend_q |-> req_valid && req_nmi); // R8

endmodule

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;

  localparam logic [31:0] LVL = 32'h0000_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        nmi_in = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] full_addr = '0;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        req_valid, req_nmi, req_ack = 1'b0, cpl = 1'b0;
  logic [4:0]  req_id;

  assign bus_addr = full_addr[11:2];
  always #2.5 clk = ~clk;

  prio_intc #(.LEVEL_MASK(LVL)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_nmi(req_nmi), .req_id(req_id),
    .req_ack(req_ack), .cpl(cpl)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] m_en = '0, m_pend = '0, m_act = '0, m_prev = '0;
  logic [1:0]  m_pr [32];
  logic        m_np = 0, m_na = 0, m_nprev = 0;
  logic [31:0] e_act;
  logic        e_na, e_valid, e_nmi;
  logic [4:0]  e_id;

  initial for (int i = 0; i < 32; i++) m_pr[i] = 2'd0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int best(input logic [31:0] m, input int ceil);
    int b = -1;
    int lv = ceil;
    for (int i = 0; i < 32; i++)
      if (m[i] && int'(m_pr[i]) < lv) begin lv = int'(m_pr[i]); b = i; end
    return b;
  endfunction

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    logic [31:0] r = '0;
    int w = int'(a[11:2]);
    if (w == 'h00 || w == 'h20) r = m_en;
    else if (w == 'h40 || w == 'h60) r = m_pend;
    else if (w >= 'hC0 && w < 'hC8)
      for (int j = 0; j < 4; j++) r[8*j+6 +: 2] = m_pr[4*(w-'hC0)+j];
    return r;
  endfunction

  task automatic model_eval();
    int b, c, ceil;
    e_act = m_act; e_na = m_na;
    if (cpl) begin
      if (m_na) e_na = 0;
      else begin b = best(m_act, 4); if (b >= 0) e_act[b] = 1'b0; end
    end
    b = best(e_act, 4);
    ceil = (b >= 0) ? int'(m_pr[b]) : 4;
    e_valid = 0; e_nmi = 0; e_id = '0;
    if (m_np && !e_na) begin e_valid = 1; e_nmi = 1; end
    else if (!e_na) begin
      c = best(m_en & m_pend, ceil);
      if (c >= 0) begin e_valid = 1; e_id = 5'(c); end
    end
  endtask

  task automatic model_update();
    logic [31:0] hw, bset, bclr, aclr;
    int w;
    logic take;
    hw = (irq_in & LVL) | (irq_in & ~m_prev & ~LVL);
    take = e_valid && req_ack;
    aclr = (take && !e_nmi) ? (32'd1 << e_id) : '0;
    bset = '0; bclr = '0;
    w = int'(full_addr[11:2]);
    if (bus_valid && bus_write) begin
      if (w == 'h00) m_en = m_en | bus_wdata;
      if (w == 'h20) m_en = m_en & ~bus_wdata;
      if (w == 'h40) bset = bus_wdata;
      if (w == 'h60) bclr = bus_wdata;
      if (w >= 'hC0 && w < 'hC8)
        for (int j = 0; j < 4; j++) m_pr[4*(w-'hC0)+j] = bus_wdata[8*j+6 +: 2];
    end
    m_pend  = (m_pend & ~bclr & ~aclr) | bset | hw;
    m_np    = (m_np & ~(take & e_nmi)) | (nmi_in & ~m_nprev);
    m_na    = e_na | (take & e_nmi);
    m_act   = e_act | aclr;
    m_prev  = irq_in;
    m_nprev = nmi_in;
  endtask

  // Called just after a falling edge with inputs applied
  task automatic step(string tag);
    #1;
    model_eval();
    chk(tag, "request", {29'd0, req_valid, req_nmi, req_id} & 32'h7F,
        {25'd0, e_valid, e_nmi, e_id});
    chk(tag, "rdata", bus_rdata, rd_model(full_addr));
    @(posedge clk);
    model_update();
    @(negedge clk);
    bus_valid = 0; bus_write = 0; req_ack = 0; cpl = 0;
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d, string tag);
    bus_valid = 1; bus_write = 1; full_addr = a; bus_wdata = d;
    step(tag);
  endtask

  task automatic rdc(logic [31:0] a, string tag);
    full_addr = a; step(tag);
  endtask

  function automatic logic [31:0] pick_addr(int k);
    if (k < 4) return 32'(k) * 32'h80;
    if (k < 12) return 32'h300 + 32'(4 * (k - 4));
    return 32'h040;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int k = 0; k < 13; k++) rdc(pick_addr(k), "R1");

    // R2 enable pair
    wr(32'h000, 32'h0000_F0F5, "R2");
    rdc(32'h080, "R2");
    wr(32'h000, 32'h0, "R2");
    wr(32'h080, 32'h0, "R2");
    rdc(32'h000, "R2");
    wr(32'h080, 32'h0000_0005, "R2");
    rdc(32'h080, "R2");

    // R4 priority layout
    wr(32'h304, 32'hFFFF_FFFF, "R4");
    rdc(32'h304, "R4");
    wr(32'h31C, 32'h4080_C000, "R4");
    rdc(32'h31C, "R4");
    rdc(32'h318, "R4");

    // R3 pending pair, line 8 not enabled so no offer
    wr(32'h100, 32'h0000_0100, "R3");
    rdc(32'h180, "R3");
    wr(32'h100, 32'h0, "R3");
    wr(32'h180, 32'h0000_0100, "R3");
    rdc(32'h100, "R3");

    // R5 pulse line held high, cleared flag stays clear
    irq_in[20] = 1;
    rdc(32'h100, "R5"); rdc(32'h100, "R5"); rdc(32'h100, "R5");
    wr(32'h180, 32'h0010_0000, "R5");
    rdc(32'h100, "R5"); rdc(32'h100, "R5");
    irq_in[20] = 0;
    // R5 level line re-marks pending while high
    irq_in[3] = 1;
    rdc(32'h100, "R5");
    wr(32'h180, 32'h0000_0008, "R5");
    rdc(32'h100, "R5");
    irq_in[3] = 0;
    wr(32'h180, 32'h0000_0008, "R5");
    rdc(32'h100, "R5");

    // R6 arbitration: line 5 at level 3, lines 9 and 10 at level 0
    wr(32'h000, 32'hFFFF_FFFF, "R6");
    wr(32'h100, 32'h0000_0620, "R6");
    rdc(32'h100, "R6");
    // R7 acknowledge then same-level blocking
    req_ack = 1; step("R7");
    rdc(32'h100, "R7"); rdc(32'h100, "R7");
    // R8 completion plus acknowledge in one cycle
    cpl = 1; req_ack = 1; step("R8");
    rdc(32'h100, "R8");
    cpl = 1; req_ack = 1; step("R8");
    // R7 preemption: line 30 at level 2 while line 5 (level 3) is active
    wr(32'h100, 32'h4000_0000, "R7");
    req_ack = 1; step("R7");
    cpl = 1; step("R8");
    cpl = 1; step("R8");
    rdc(32'h100, "R8");

    // R9 non-maskable line
    wr(32'h100, 32'h0000_0002, "R9");
    nmi_in = 1; step("R9");
    req_ack = 1; step("R9");
    step("R9");
    nmi_in = 0; step("R9");
    nmi_in = 1; step("R9");
    step("R9");
    cpl = 1; req_ack = 1; step("R8");
    nmi_in = 0;
    cpl = 1; step("R9");
    req_ack = 1; step("R9");
    cpl = 1; step("R9");

    // R10 pulse edge coinciding with acknowledge and with software clear
    irq_in[25] = 1; step("R10");
    irq_in[25] = 0; step("R10");
    irq_in[25] = 1; req_ack = 1; step("R10");
    rdc(32'h100, "R10");
    irq_in[25] = 0; step("R10");
    irq_in[25] = 1; bus_valid = 1; bus_write = 1; full_addr = 32'h180; bus_wdata = 32'h0200_0000;
    step("R10");
    rdc(32'h100, "R10");
    cpl = 1; step("R10");
    irq_in = '0;

    // Constrained random mix, judged by the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 6 == 0) irq_in[$urandom % 32] ^= 1'b1;
      if ($urandom % 40 == 0) nmi_in = ~nmi_in;
      req_ack = ($urandom % 2) == 0;
      cpl = ($urandom % 5) == 0;
      full_addr = pick_addr(int'($urandom % 13));
      if ($urandom % 4 == 0) begin
        bus_valid = 1; bus_write = 1;
        bus_wdata = ($urandom % 3 == 0) ? 32'(1 << ($urandom % 32)) : $urandom;
      end
      step("R6");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule